// File: doc/BRIEF.md
# Clock Synthesizer Programming Sequencer

This block sits between a host register bus and an external programmable clock synthesizer. The host first stages three 16-bit configuration words in three clock control registers. It then commits them by writing the value 1 to a trigger register. On that commit the sequencer shifts the staged words out over a three-wire serial link: a serial clock, a data line and a latch strobe.

For the whole programming interval the block holds a busy flag, and it only then raises a ready flag telling the rest of the chip that the synthesized clock may be used. The interval is about 1.2 ms, counted in system clock cycles from the clock frequency parameter. The load cannot be interrupted from the bus. A reset in the middle of it abandons the load, and the host must stage all three words and trigger again.

Top module: `clk_synth_prog`

## Requirements
- R1: The three clock control registers sit at byte offsets 0x18, 0x1A and 0x1C. A bus write to one of them stores the 16-bit data, and a read of the same offset returns it.
- R2: A write of exactly 0x0001 to byte offset 0x1E while idle starts programming: busy is 1 in the cycle after the write edge. A write of any other value to 0x1E is ignored.
- R3: Busy stays high for exactly PROG_CYCLES = (CLK_FREQ_HZ/1000)*PROG_TIME_US/1000 clock cycles. Ready rises on the same edge that busy falls, and busy and ready are never high together.
- R4: The words are sent in register order 0x18, 0x1A, 0x1C, each MSB first. The synthesizer samples the data line on each rising edge of the serial clock. The serial clock stays high and low for DIV_CYCLES system cycles each, and the data line is stable while it is high. After the 16th bit of each word, one latch pulse is sent with the serial clock low.
- R5: While busy, writes to the configuration registers and to the trigger register are ignored. The registers read back their staged values afterwards, and exactly three words are sent.
- R6: A read of offset 0x1E returns busy in bit 0 and ready in bit 1, with all other bits 0.
- R7: Reset (rstN low) clears all three configuration registers, busy, ready and the serial outputs. After a reset in the middle of programming, ready stays low and the serial clock stays idle until a new trigger runs to completion.
- R8: An accepted trigger clears ready, which stays low until that programming run completes.
- R9: Bus reads of offsets not named in R1 and R6 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrData | input | WORD_W | Write data |
| busRdData | output | WORD_W | Read data for busAddr (combinational) |
| synthSclk | output | 1 | Serial clock to the synthesizer |
| synthSdata | output | 1 | Serial data to the synthesizer |
| synthLatch | output | 1 | Word latch strobe to the synthesizer |
| progBusy | output | 1 | Programming in progress |
| clkReady | output | 1 | Synthesized clock usable |

## Verification
The bench attaches a bit-level synthesizer model that rebuilds the words from the serial clock and latch pulses. A wrong bit order, a swapped word order or a latch sent at the wrong bit count therefore shows up as corrupted or misframed words. It writes to the configuration registers and the trigger register while busy. A design that accepted these writes would change the data being sent or restart the interval, which would lengthen the busy window. It counts the busy window cycle by cycle, so an off-by-one interval counter is reported. It also resets the block halfway through a load. A design that kept ready, kept the staged words or resumed shifting after that reset would be caught by the readbacks and the idle serial clock.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CLK_LOW,
    SEQ_CLK_HIGH,
    SEQ_LATCH,
    SEQ_SETTLE
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startLoad;
    logic divReload;
    logic shiftAdv;
    logic wordAdv;
    logic holdRegs;
  } seqCtrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic trigHit;
    logic divDone;
    logic bitLast;
    logic wordLast;
    logic intervalDone;
  } seqStat_t;

endpackage

// File: rtl/clk_synth_datapath.sv
module clk_synth_datapath
  import clk_synth_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned NUM_WORDS   = 3,
  parameter int unsigned CFG_BASE    = 'h18,
  parameter int unsigned TRIG_OFS    = 'h1E,
  parameter int unsigned DIV_CYCLES  = 4,
  parameter int unsigned PROG_CYCLES = 240000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  seqCtrl_t          ctrl,
  output seqStat_t          stat,
  input  logic              busy,
  input  logic              ready,
  output logic              serData
);

  localparam int unsigned SHIFT_W = WORD_W * NUM_WORDS;
  localparam int unsigned BIT_CW  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int unsigned WORD_CW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned DIV_CW  = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
  localparam int unsigned INT_CW  = $clog2(PROG_CYCLES + 1);
  localparam int unsigned STRIDE  = (WORD_W + 7) / 8;

  logic [WORD_W-1:0]  cfgWords [NUM_WORDS];
  logic [SHIFT_W-1:0] cfgFlat;
  logic [SHIFT_W-1:0] shiftReg;
  logic [DIV_CW-1:0]  divCnt;
  logic [BIT_CW-1:0]  bitCnt;
  logic [WORD_CW-1:0] wordCnt;
  logic [INT_CW-1:0]  intCnt;

  // Staged configuration registers, first register in the top slice
  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_cfg
    logic hit;
    assign hit = busWrEn && !ctrl.holdRegs &&
                 (busAddr == ADDR_W'(CFG_BASE + STRIDE * gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    cfgWords[gi] <= '0;
      else if (hit) cfgWords[gi] <= busWrData;
    end
    assign cfgFlat[SHIFT_W - 1 - gi * WORD_W -: WORD_W] = cfgWords[gi];
  end

  // Read mux
  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (busAddr == ADDR_W'(CFG_BASE + STRIDE * i)) busRdData = cfgWords[i];
    end
    if (busAddr == ADDR_W'(TRIG_OFS)) begin
      busRdData[0] = busy;
      busRdData[1] = ready;
    end
  end

  assign stat.trigHit = busWrEn && (busAddr == ADDR_W'(TRIG_OFS)) &&
                        (busWrData == WORD_W'(1));

  // Bit period divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               divCnt <= '0;
    else if (ctrl.startLoad || ctrl.divReload) divCnt <= DIV_CW'(DIV_CYCLES - 1);
    else if (divCnt != '0)                   divCnt <= divCnt - 1'b1;
  end
  assign stat.divDone = (divCnt == '0);

  // Bit and word position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (ctrl.startLoad) begin
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (ctrl.wordAdv) begin
      bitCnt  <= '0;
      wordCnt <= wordCnt + 1'b1;
    end else if (ctrl.shiftAdv) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end
  assign stat.bitLast  = (bitCnt == BIT_CW'(WORD_W - 1));
  assign stat.wordLast = (wordCnt == WORD_CW'(NUM_WORDS - 1));

  // Programming interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intCnt <= '0;
    else if (ctrl.startLoad) intCnt <= INT_CW'(PROG_CYCLES - 1);
    else if (intCnt != '0)   intCnt <= intCnt - 1'b1;
  end
  assign stat.intervalDone = (intCnt == '0);

  // Serial shift register, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (ctrl.startLoad) shiftReg <= cfgFlat;
    else if (ctrl.shiftAdv)  shiftReg <= {shiftReg[SHIFT_W-2:0], 1'b0};
  end
  assign serData = shiftReg[SHIFT_W-1];

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdRegs |=> $stable(cfgFlat));

  // R4
  word_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftAdv |-> (wordCnt <= WORD_CW'(NUM_WORDS - 1)));

endmodule

// File: rtl/clk_synth_ctrl.sv
module clk_synth_ctrl
  import clk_synth_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     serClk,
  output logic     serLatch,
  output logic     busy,
  output logic     ready
);

  seqState_e state, stateNext;
  logic      finish;

  always_comb begin
    ctrl          = '0;
    stateNext     = state;
    finish        = 1'b0;
    ctrl.holdRegs = (state != SEQ_IDLE);
    unique case (state)
      SEQ_IDLE: begin
        if (stat.trigHit) begin
          ctrl.startLoad = 1'b1;
          stateNext      = SEQ_CLK_LOW;
        end
      end
      SEQ_CLK_LOW: begin
        if (stat.divDone) begin
          ctrl.divReload = 1'b1;
          stateNext      = SEQ_CLK_HIGH;
        end
      end
      SEQ_CLK_HIGH: begin
        if (stat.divDone) begin
          ctrl.divReload = 1'b1;
          ctrl.shiftAdv  = 1'b1;
          stateNext      = stat.bitLast ? SEQ_LATCH : SEQ_CLK_LOW;
        end
      end
      SEQ_LATCH: begin
        if (stat.divDone) begin
          ctrl.divReload = 1'b1;
          ctrl.wordAdv   = 1'b1;
          stateNext      = stat.wordLast ? SEQ_SETTLE : SEQ_CLK_LOW;
        end
      end
      SEQ_SETTLE: begin
        if (stat.intervalDone) begin
          finish    = 1'b1;
          stateNext = SEQ_IDLE;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ready <= 1'b0;
    else if (ctrl.startLoad) ready <= 1'b0;
    else if (finish)         ready <= 1'b1;
  end

  assign serClk   = (state == SEQ_CLK_HIGH);
  assign serLatch = (state == SEQ_LATCH);
  assign busy     = (state != SEQ_IDLE);

  // R3
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && ready));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $fell(busy));

  // R4
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    serLatch |-> (!serClk && busy));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.startLoad |=> (busy && !ready));

endmodule

// File: rtl/clk_synth_prog.sv
module clk_synth_prog
  import clk_synth_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned NUM_WORDS    = 3,
  parameter int unsigned CFG_BASE     = 'h18,
  parameter int unsigned TRIG_OFS     = 'h1E,
  parameter int unsigned DIV_CYCLES   = 4,
  parameter int unsigned CLK_FREQ_HZ  = 200000000,
  parameter int unsigned PROG_TIME_US = 1200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic              synthSclk,
  output logic              synthSdata,
  output logic              synthLatch,
  output logic              progBusy,
  output logic              clkReady
);

  localparam int unsigned PROG_CYCLES = (CLK_FREQ_HZ / 1000) * PROG_TIME_US / 1000;

  seqCtrl_t ctrl;
  seqStat_t stat;

  clk_synth_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .NUM_WORDS  (NUM_WORDS),
    .CFG_BASE   (CFG_BASE),
    .TRIG_OFS   (TRIG_OFS),
    .DIV_CYCLES (DIV_CYCLES),
    .PROG_CYCLES(PROG_CYCLES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .ctrl     (ctrl),
    .stat     (stat),
    .busy     (progBusy),
    .ready    (clkReady),
    .serData  (synthSdata)
  );

  clk_synth_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .ctrl    (ctrl),
    .serClk  (synthSclk),
    .serLatch(synthLatch),
    .busy    (progBusy),
    .ready   (clkReady)
  );

  // R4
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (synthSclk && $past(synthSclk)) |-> $stable(synthSdata));

  // R7
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !progBusy |-> (!synthSclk && !synthLatch));

endmodule

// File: tb/test_clk_synth_prog.sv
`timescale 1ns/1ps
module test_clk_synth_prog;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DIV    = 2;
  localparam int unsigned FREQ   = 250000;
  localparam int unsigned PROG   = (FREQ / 1000) * 1200 / 1000; // 300

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [WORD_W-1:0] busWrData = '0;
  logic [WORD_W-1:0] busRdData;
  logic synthSclk, synthSdata, synthLatch, progBusy, clkReady;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int busyRun = 0;

  // Synthesizer model
  logic [15:0] modelSr = '0;
  int          modelBits = 0;
  int          modelCount = 0;
  int          modelBad = 0;
  logic [15:0] modelWords [3];

  clk_synth_prog #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .DIV_CYCLES  (DIV),
    .CLK_FREQ_HZ (FREQ),
    .PROG_TIME_US(1200)
  ) i_clk_synth_prog (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .synthSclk (synthSclk),
    .synthSdata(synthSdata),
    .synthLatch(synthLatch),
    .progBusy  (progBusy),
    .clkReady  (clkReady)
  );

  always #2.5 clk = ~clk;

  always @(posedge synthSclk) begin
    modelSr   = {modelSr[14:0], synthSdata};
    modelBits = modelBits + 1;
  end

  always @(posedge synthLatch) begin
    if (modelBits != 16 || modelCount >= 3) modelBad = modelBad + 1;
    else modelWords[modelCount] = modelSr;
    modelCount = modelCount + 1;
    modelBits  = 0;
  end

  always @(negedge clk) if (progBusy) busyRun = busyRun + 1;

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    modelBits = 0; modelCount = 0; modelBad = 0;
    for (int i = 0; i < 3; i++) modelWords[i] = '0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    clearModel();
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && progBusy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    applyReset();
    check("R7 busy after reset", progBusy, 0);
    check("R7 ready after reset", clkReady, 0);
    check("R7 serial outputs after reset", {synthSclk, synthSdata, synthLatch}, 0);
    busRead(8'h1E, d); check("R6 status after reset", d, 16'h0000);
    busRead(8'h18, d); check("R7 cfg1 cleared", d, 16'h0000);
    busRead(8'h1C, d); check("R7 cfg3 cleared", d, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    busWrite(8'h18, 16'h1357);
    busWrite(8'h1A, 16'h2468);
    busWrite(8'h1C, 16'hACE1);
    busRead(8'h18, d); check("R1 cfg1 readback", d, 16'h1357);
    busRead(8'h1A, d); check("R1 cfg2 readback", d, 16'h2468);
    busRead(8'h1C, d); check("R1 cfg3 readback", d, 16'hACE1);
    busWrite(8'h16, 16'hFFFF);
    busWrite(8'h19, 16'hFFFF);
    busRead(8'h16, d); check("R9 unmapped read 0x16", d, 16'h0000);
    busRead(8'h20, d); check("R9 unmapped read 0x20", d, 16'h0000);
    busRead(8'h18, d); check("R9 cfg1 untouched", d, 16'h1357);
    busRead(8'h1A, d); check("R9 cfg2 untouched", d, 16'h2468);
  endtask

  task automatic t_badTrigger();
    busWrite(8'h1E, 16'h0002);
    busWrite(8'h1E, 16'h0101);
    repeat (3) @(negedge clk);
    check("R2 non-1 trigger ignored", progBusy, 0);
    check("R2 no serial clock", modelBits, 0);
  endtask

  task automatic t_program(input logic [15:0] w1, input logic [15:0] w2,
                           input logic [15:0] w3, input bit readyBefore);
    logic [15:0] d;
    clearModel();
    busWrite(8'h18, w1);
    busWrite(8'h1A, w2);
    busWrite(8'h1C, w3);
    check("R3 ready level before trigger", clkReady, readyBefore);
    busyRun = 0;
    busWrite(8'h1E, 16'h0001);
    check("R2 busy after trigger", progBusy, 1);
    check("R8 ready cleared by trigger", clkReady, 0);
    busRead(8'h1E, d); check("R6 status while busy", d, 16'h0001);
    busWrite(8'h18, ~w1);
    busWrite(8'h1C, ~w3);
    busWrite(8'h1E, 16'h0001);
    waitIdle();
    check("R3 busy window length", busyRun, PROG);
    check("R3 ready after completion", clkReady, 1);
    busRead(8'h1E, d); check("R6 status when done", d, 16'h0002);
    check("R4 latch count", modelCount, 3);
    check("R4 framing", modelBad, 0);
    check("R4 word1 serial", modelWords[0], w1);
    check("R4 word2 serial", modelWords[1], w2);
    check("R4 word3 serial", modelWords[2], w3);
    busRead(8'h18, d); check("R5 cfg1 kept while busy", d, w1);
    busRead(8'h1C, d); check("R5 cfg3 kept while busy", d, w3);
  endtask

  task automatic t_midReset();
    logic [15:0] d;
    busWrite(8'h18, 16'h0F0F);
    busWrite(8'h1A, 16'hF0F0);
    busWrite(8'h1C, 16'h5555);
    busWrite(8'h1E, 16'h0001);
    repeat (60) @(negedge clk);
    applyReset();
    check("R7 busy after mid reset", progBusy, 0);
    check("R7 ready after mid reset", clkReady, 0);
    busRead(8'h1A, d); check("R7 cfg2 cleared by mid reset", d, 16'h0000);
    repeat (PROG + 20) @(negedge clk);
    check("R7 no resumed shifting", modelBits, 0);
    check("R7 ready stays low", clkReady, 0);
    t_program(16'h0F0F, 16'hF0F0, 16'h5555, 1'b0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_badTrigger();
    t_program(16'hA5C3, 16'h0F0F, 16'h8001, 1'b0);
    t_program(16'hFFFF, 16'h0000, 16'h1234, 1'b1);
    t_midReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule